// File: doc/BRIEF.md
# Memory granule version checker

This block guards memory accesses with version tags. Memory is split into 64-byte granules, and each granule holds a 4-bit version in an internal store. Each access arrives with four pieces of information: the version field of the capability that authorizes it, the access kind and the granule address. It also carries one pass/fail bit that sums up all other checks, such as bounds, permissions and translation. One cycle later the block answers with a verdict. The access either proceeds or is squashed. A squash depends on the access kind: a load yields zero data, a capability load yields an untagged null, a store is quietly dropped, and an instruction fetch traps.

Version 0 on a capability means "unversioned", and such a capability reaches any granule. The same request port also carries three commands:
- set one granule's version;
- read one granule's version;
- read the versions of a whole group of adjacent granules, packed into one word.

All three commands need an unversioned capability. A separate combinational helper computes the version and tag of a capability that is re-derived with a requested version.

A strict mode input makes mismatching data loads and stores trap as well, which helps with debugging. It is off in normal use.

Top module: `granule_version_guard`

## Requirements
- R1: After reset every granule version is 0 and `rsp_valid` is low.
- R2: A request sampled with `req_valid` high gives a response with `rsp_valid` high exactly one clock later. An idle cycle gives `rsp_valid` low one clock later.
- R3: An access (op 0 data load, 1 capability load, 2 store, 3 fetch) with capability version 0 and `req_perm_ok` high passes, whatever the granule's version.
- R4: An access with a nonzero capability version and `req_perm_ok` high passes only when the capability version equals the granule's version.
- R5: A mismatching data load raises `rsp_zero_data`. It leaves `rsp_pass` low and, when strict mode is off, `rsp_trap` low.
- R6: A mismatching capability load raises only `rsp_null_cap`, whether or not strict mode is on.
- R7: A mismatching store raises `rsp_drop_store`. When strict mode is off it leaves `rsp_trap` low.
- R8: A mismatching instruction fetch raises only `rsp_trap`.
- R9: When `req_perm_ok` is low, any op gives `rsp_trap` high and `rsp_pass` low. The reserved op 7 also traps.
- R10: Op 4 (set version) with capability version 0 and `req_perm_ok` high writes `req_wr_ver` to the granule, and an access in the next cycle already sees the new value. With a nonzero capability version it traps and leaves the granule unchanged.
- R11: Op 5 (read version) with capability version 0 returns the granule's version in `rsp_rdata[3:0]`, with all upper bits zero. With a nonzero capability version it traps and returns zero.
- R12: Op 6 (group read) with capability version 0 returns the versions of the LINE_GRANS granules that share the address bits above the low log2(LINE_GRANS) bits. Granule k of the group sits at `rsp_rdata[4k+3:4k]`.
- R13: With `strict_mode` high, a mismatching data load or store also raises `rsp_trap`, in addition to its squash flag.
- R14: The derive helper sets `drv_ver` to the requested version. A requested version of 0 raises `drv_trap` and clears `drv_tag`. A source at version 0 keeps `drv_src_tag`. A versioned source keeps its tag only if its version equals the requested one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 load, 1 cap load, 2 store, 3 fetch, 4 set version, 5 read version, 6 group read, 7 reserved |
| req_gaddr | input | GADDR_W | Granule address |
| req_cap_ver | input | VER_W | Version field of the authorizing capability |
| req_wr_ver | input | VER_W | Version to write for op 4 |
| req_perm_ok | input | 1 | Result of all other checks |
| strict_mode | input | 1 | Trap on mismatching data loads and stores |
| rsp_valid | output | 1 | Response present |
| rsp_pass | output | 1 | Access or command proceeds |
| rsp_zero_data | output | 1 | Load returns zero |
| rsp_null_cap | output | 1 | Capability load returns untagged null |
| rsp_drop_store | output | 1 | Store is discarded |
| rsp_trap | output | 1 | Trap raised |
| rsp_rdata | output | LINE_GRANS*VER_W | Version read data |
| drv_src_ver | input | VER_W | Version of source capability |
| drv_src_tag | input | 1 | Tag of source capability |
| drv_req_ver | input | VER_W | Requested version |
| drv_ver | output | VER_W | Derived version |
| drv_tag | output | 1 | Derived tag |
| drv_trap | output | 1 | Derive traps |

## Verification
The assertions check on every cycle that:
- each response follows its request by one cycle;
- at most one of pass and the three squash flags is high;
- a pass never comes with a trap;
- a failed permission input always traps;
- an unversioned access always passes;
- a fetch is never squashed silently;
- a command from a versioned capability traps;
- a zero requested version in the derive helper traps.

The checks that depend on stored versions need the bench's reference model of the version store. These are the exact match or mismatch outcome, the read-back values, the packing order of the group read, the write followed at once by a use, and the strict-mode variants.

// File: rtl/gvc_pkg.sv
package gvc_pkg;

  typedef enum logic [2:0] {
    OP_DLOAD   = 3'd0,
    OP_CLOAD   = 3'd1,
    OP_STORE   = 3'd2,
    OP_FETCH   = 3'd3,
    OP_SETVER  = 3'd4,
    OP_GETVER  = 3'd5,
    OP_GETLINE = 3'd6,
    OP_RSVD    = 3'd7
  } gvc_op_e;

  typedef struct packed {
    logic pass;
    logic zero_data;
    logic null_cap;
    logic drop_store;
    logic trap;
  } gvc_verdict_t;

endpackage

// File: rtl/gvc_bank.sv
module gvc_bank #(
  parameter int VER_W = 4,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VER_W-1:0] wr_ver,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VER_W-1:0] rd_ver
);
  localparam int DEPTH = 1 << IDX_W;

  logic [VER_W-1:0] mem [DEPTH];

  // storage: written on enable, cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_ver;
    end
  end

  // registered read port: sees contents from before a same-edge write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_ver <= '0;
    else if (rd_en) rd_ver <= mem[rd_idx];
  end

endmodule

// File: rtl/gvc_decide.sv
module gvc_decide
  import gvc_pkg::*;
#(
  parameter int VER_W      = 4,
  parameter int LINE_GRANS = 4
) (
  input  logic                        valid,
  input  gvc_op_e                     op,
  input  logic [VER_W-1:0]            cap_ver,
  input  logic                        perm_ok,
  input  logic                        strict,
  input  logic [VER_W-1:0]            gran_ver,
  input  logic [LINE_GRANS*VER_W-1:0] line_ver,
  output gvc_verdict_t                verdict,
  output logic [LINE_GRANS*VER_W-1:0] rdata
);
  logic unversioned;
  logic match;
  logic cmd_ok;

  assign unversioned = (cap_ver == '0);
  assign match       = unversioned || (cap_ver == gran_ver);
  assign cmd_ok      = perm_ok && unversioned;

  always_comb begin
    verdict = '0;
    rdata   = '0;
    if (valid) begin
      if (!perm_ok) begin
        verdict.trap = 1'b1;
      end else begin
        unique case (op)
          OP_DLOAD: begin
            verdict.pass      = match;
            verdict.zero_data = !match;
            verdict.trap      = !match && strict;
          end
          OP_CLOAD: begin
            verdict.pass     = match;
            verdict.null_cap = !match;
          end
          OP_STORE: begin
            verdict.pass       = match;
            verdict.drop_store = !match;
            verdict.trap       = !match && strict;
          end
          OP_FETCH: begin
            verdict.pass = match;
            verdict.trap = !match;
          end
          OP_SETVER: begin
            verdict.pass = cmd_ok;
            verdict.trap = !cmd_ok;
          end
          OP_GETVER: begin
            verdict.pass = cmd_ok;
            verdict.trap = !cmd_ok;
            if (cmd_ok) rdata[VER_W-1:0] = gran_ver;
          end
          OP_GETLINE: begin
            verdict.pass = cmd_ok;
            verdict.trap = !cmd_ok;
            if (cmd_ok) rdata = line_ver;
          end
          default: begin
            verdict.trap = 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/gvc_derive.sv
module gvc_derive #(
  parameter int VER_W = 4
) (
  input  logic [VER_W-1:0] src_ver,
  input  logic             src_tag,
  input  logic [VER_W-1:0] want_ver,
  output logic [VER_W-1:0] out_ver,
  output logic             out_tag,
  output logic             out_trap
);
  always_comb begin
    out_ver  = want_ver;
    out_trap = 1'b0;
    out_tag  = src_tag;
    if (want_ver == '0) begin
      out_trap = 1'b1;
      out_tag  = 1'b0;
    end else if (src_ver != '0) begin
      out_tag = src_tag && (src_ver == want_ver);
    end
  end
endmodule

// File: rtl/granule_version_guard.sv
module granule_version_guard
  import gvc_pkg::*;
#(
  parameter int VER_W      = 4,
  parameter int GADDR_W    = 8,
  parameter int LINE_GRANS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [2:0]                  req_op,
  input  logic [GADDR_W-1:0]          req_gaddr,
  input  logic [VER_W-1:0]            req_cap_ver,
  input  logic [VER_W-1:0]            req_wr_ver,
  input  logic                        req_perm_ok,
  input  logic                        strict_mode,
  output logic                        rsp_valid,
  output logic                        rsp_pass,
  output logic                        rsp_zero_data,
  output logic                        rsp_null_cap,
  output logic                        rsp_drop_store,
  output logic                        rsp_trap,
  output logic [LINE_GRANS*VER_W-1:0] rsp_rdata,
  input  logic [VER_W-1:0]            drv_src_ver,
  input  logic                        drv_src_tag,
  input  logic [VER_W-1:0]            drv_req_ver,
  output logic [VER_W-1:0]            drv_ver,
  output logic                        drv_tag,
  output logic                        drv_trap
);
  // LINE_GRANS must be a power of two, at least 2
  localparam int SEL_W  = $clog2(LINE_GRANS);
  localparam int LINE_W = GADDR_W - SEL_W;
  localparam int DATA_W = LINE_GRANS * VER_W;

  gvc_op_e           op_in;
  logic [SEL_W-1:0]  sel_in;
  logic [LINE_W-1:0] line_in;
  logic              wr_fire;

  assign op_in   = gvc_op_e'(req_op);
  assign sel_in  = req_gaddr[SEL_W-1:0];
  assign line_in = req_gaddr[GADDR_W-1:SEL_W];
  assign wr_fire = req_valid && (op_in == OP_SETVER) && req_perm_ok && (req_cap_ver == '0);

  // ---- request stage: next-state and registers ----
  logic             s_valid_q, s_valid_d;
  gvc_op_e          s_op_q, s_op_d;
  logic [VER_W-1:0] s_cap_q, s_cap_d;
  logic             s_perm_q, s_perm_d;
  logic             s_strict_q, s_strict_d;
  logic [SEL_W-1:0] s_sel_q, s_sel_d;
  logic             s_load;

  assign s_load = req_valid;

  always_comb begin
    s_valid_d  = req_valid;
    s_op_d     = s_op_q;
    s_cap_d    = s_cap_q;
    s_perm_d   = s_perm_q;
    s_strict_d = s_strict_q;
    s_sel_d    = s_sel_q;
    if (s_load) begin
      s_op_d     = op_in;
      s_cap_d    = req_cap_ver;
      s_perm_d   = req_perm_ok;
      s_strict_d = strict_mode;
      s_sel_d    = sel_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid_q  <= 1'b0;
      s_op_q     <= OP_DLOAD;
      s_cap_q    <= '0;
      s_perm_q   <= 1'b0;
      s_strict_q <= 1'b0;
      s_sel_q    <= '0;
    end else begin
      s_valid_q  <= s_valid_d;
      s_op_q     <= s_op_d;
      s_cap_q    <= s_cap_d;
      s_perm_q   <= s_perm_d;
      s_strict_q <= s_strict_d;
      s_sel_q    <= s_sel_d;
    end
  end

  // ---- version store: one bank per granule position in a group ----
  logic [DATA_W-1:0] line_q;

  for (genvar g = 0; g < LINE_GRANS; g++) begin : g_bank
    logic bank_wr;
    assign bank_wr = wr_fire && (sel_in == SEL_W'(g));
    gvc_bank #(.VER_W(VER_W), .IDX_W(LINE_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_wr),
      .wr_idx (line_in),
      .wr_ver (req_wr_ver),
      .rd_en  (req_valid),
      .rd_idx (line_in),
      .rd_ver (line_q[g*VER_W +: VER_W])
    );
  end

  logic [VER_W-1:0] gran_q;
  assign gran_q = line_q[s_sel_q*VER_W +: VER_W];

  // ---- verdict ----
  gvc_verdict_t verdict;

  gvc_decide #(.VER_W(VER_W), .LINE_GRANS(LINE_GRANS)) u_decide (
    .valid    (s_valid_q),
    .op       (s_op_q),
    .cap_ver  (s_cap_q),
    .perm_ok  (s_perm_q),
    .strict   (s_strict_q),
    .gran_ver (gran_q),
    .line_ver (line_q),
    .verdict  (verdict),
    .rdata    (rsp_rdata)
  );

  assign rsp_valid      = s_valid_q;
  assign rsp_pass       = verdict.pass;
  assign rsp_zero_data  = verdict.zero_data;
  assign rsp_null_cap   = verdict.null_cap;
  assign rsp_drop_store = verdict.drop_store;
  assign rsp_trap       = verdict.trap;

  // ---- derive helper ----
  gvc_derive #(.VER_W(VER_W)) u_derive (
    .src_ver  (drv_src_ver),
    .src_tag  (drv_src_tag),
    .want_ver (drv_req_ver),
    .out_ver  (drv_ver),
    .out_tag  (drv_tag),
    .out_trap (drv_trap)
  );

endmodule

// File: rtl/gvc_checker.sv
module gvc_checker #(
  parameter int VER_W      = 4,
  parameter int GADDR_W    = 8,
  parameter int LINE_GRANS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [2:0]         req_op,
  input logic [VER_W-1:0]   req_cap_ver,
  input logic               req_perm_ok,
  input logic               rsp_valid,
  input logic               rsp_pass,
  input logic               rsp_zero_data,
  input logic               rsp_null_cap,
  input logic               rsp_drop_store,
  input logic               rsp_trap,
  input logic [VER_W-1:0]   drv_req_ver,
  input logic               drv_tag,
  input logic               drv_trap
);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_pass, rsp_zero_data, rsp_null_cap, rsp_drop_store}));

  assert_pass_no_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pass |-> !rsp_trap);

  assert_perm_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_perm_ok) |=> (rsp_trap && !rsp_pass));

  assert_unversioned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op <= 3'd3 && req_cap_ver == '0 && req_perm_ok) |=> rsp_pass);

  assert_fetch_loud_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3) |=> (!rsp_zero_data && !rsp_null_cap && !rsp_drop_store));

  assert_cmd_versioned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op >= 3'd4 && req_cap_ver != '0) |=> (rsp_trap && !rsp_pass));

  always_comb begin
    if (rst_n && drv_req_ver == '0) begin
      assert_derive_zero_R14: assert (drv_trap && !drv_tag);
    end
  end
endmodule

bind granule_version_guard gvc_checker #(
  .VER_W(VER_W), .GADDR_W(GADDR_W), .LINE_GRANS(LINE_GRANS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_op         (req_op),
  .req_cap_ver    (req_cap_ver),
  .req_perm_ok    (req_perm_ok),
  .rsp_valid      (rsp_valid),
  .rsp_pass       (rsp_pass),
  .rsp_zero_data  (rsp_zero_data),
  .rsp_null_cap   (rsp_null_cap),
  .rsp_drop_store (rsp_drop_store),
  .rsp_trap       (rsp_trap),
  .drv_req_ver    (drv_req_ver),
  .drv_tag        (drv_tag),
  .drv_trap       (drv_trap)
);

// File: tb/sim_granule_version_guard.sv
`timescale 1ns/1ps
module sim_granule_version_guard;
  localparam int VER_W = 4;
  localparam int GADDR_W = 8;
  localparam int LINE_GRANS = 4;
  localparam int NGRAN = 1 << GADDR_W;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [2:0] req_op;
  logic [GADDR_W-1:0] req_gaddr;
  logic [VER_W-1:0] req_cap_ver, req_wr_ver;
  logic req_perm_ok, strict_mode;
  logic rsp_valid, rsp_pass, rsp_zero_data, rsp_null_cap, rsp_drop_store, rsp_trap;
  logic [LINE_GRANS*VER_W-1:0] rsp_rdata;
  logic [VER_W-1:0] drv_src_ver, drv_req_ver, drv_ver;
  logic drv_src_tag, drv_tag, drv_trap;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int model [NGRAN];

  always #5 clk = ~clk;

  granule_version_guard #(.VER_W(VER_W), .GADDR_W(GADDR_W), .LINE_GRANS(LINE_GRANS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_gaddr(req_gaddr), .req_cap_ver(req_cap_ver), .req_wr_ver(req_wr_ver),
    .req_perm_ok(req_perm_ok), .strict_mode(strict_mode),
    .rsp_valid(rsp_valid), .rsp_pass(rsp_pass), .rsp_zero_data(rsp_zero_data),
    .rsp_null_cap(rsp_null_cap), .rsp_drop_store(rsp_drop_store), .rsp_trap(rsp_trap),
    .rsp_rdata(rsp_rdata), .drv_src_ver(drv_src_ver), .drv_src_tag(drv_src_tag),
    .drv_req_ver(drv_req_ver), .drv_ver(drv_ver), .drv_tag(drv_tag), .drv_trap(drv_trap));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One request; expected outcome from the requirements and the bench's version table.
  task automatic issue(input int op, input int addr, input int cv, input int wv,
                       input bit perm, input bit strict, input string req);
    logic [4:0] exp_f;
    longint exp_d;
    int gv;
    int base;
    gv = model[addr];
    exp_f = '0;  // {pass, zero, null, drop, trap}
    exp_d = 0;
    if (!perm) exp_f[0] = 1'b1;
    else if (op <= 3) begin
      if (cv == 0 || cv == gv) exp_f[4] = 1'b1;
      else if (op == 0) begin exp_f[3] = 1'b1; exp_f[0] = strict; end
      else if (op == 1) exp_f[2] = 1'b1;
      else if (op == 2) begin exp_f[1] = 1'b1; exp_f[0] = strict; end
      else exp_f[0] = 1'b1;
    end else if (op <= 6) begin
      if (cv != 0) exp_f[0] = 1'b1;
      else begin
        exp_f[4] = 1'b1;
        if (op == 5) exp_d = gv;
        if (op == 6) begin
          base = addr - (addr % LINE_GRANS);
          for (int k = 0; k < LINE_GRANS; k++) exp_d |= longint'(model[base + k]) << (VER_W * k);
        end
      end
    end else exp_f[0] = 1'b1;

    req_valid = 1'b1; req_op = 3'(op); req_gaddr = GADDR_W'(addr);
    req_cap_ver = VER_W'(cv); req_wr_ver = VER_W'(wv);
    req_perm_ok = perm; strict_mode = strict;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid === 1'b1, {req, " valid"}, rsp_valid, 1);
    chk({rsp_pass, rsp_zero_data, rsp_null_cap, rsp_drop_store, rsp_trap} === exp_f,
        {req, " flags"}, {rsp_pass, rsp_zero_data, rsp_null_cap, rsp_drop_store, rsp_trap}, exp_f);
    chk(longint'(rsp_rdata) == exp_d, {req, " rdata"}, rsp_rdata, exp_d);
    if (op == 4 && perm && cv == 0) model[addr] = wv;
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2 idle valid", rsp_valid, 0);
  endtask

  task automatic derive(input int sv, input bit st, input int rv,
                        input int ev, input bit et, input bit etrap, input string req);
    drv_src_ver = VER_W'(sv); drv_src_tag = st; drv_req_ver = VER_W'(rv);
    #1;
    chk({drv_ver, drv_tag, drv_trap} === {VER_W'(ev), et, etrap}, req,
        {drv_ver, drv_tag, drv_trap}, {VER_W'(ev), et, etrap});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NGRAN; i++) model[i] = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_gaddr = '0;
    req_cap_ver = '0; req_wr_ver = '0; req_perm_ok = 1'b0; strict_mode = 1'b0;
    drv_src_ver = '0; drv_src_tag = 1'b0; drv_req_ver = 4'd1;
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 reset valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 post-reset valid", rsp_valid, 0);

    issue(6, 0, 0, 0, 1, 0, "R1 R12 group read after reset");
    issue(4, 5, 0, 9, 1, 0, "R10 set 5");
    issue(4, 4, 0, 3, 1, 0, "R10 set 4");
    issue(4, 6, 0, 12, 1, 0, "R10 set 6");
    issue(4, 7, 0, 1, 1, 0, "R10 set 7");
    issue(5, 5, 0, 0, 1, 0, "R11 read 5");
    issue(6, 6, 0, 0, 1, 0, "R12 group read 4..7");
    issue(0, 5, 9, 0, 1, 0, "R4 load match");
    issue(0, 5, 0, 0, 1, 0, "R3 load unversioned");
    issue(0, 5, 2, 0, 1, 0, "R5 load mismatch");
    issue(1, 5, 2, 0, 1, 0, "R6 cap load mismatch");
    issue(2, 5, 2, 0, 1, 0, "R7 store mismatch");
    issue(3, 5, 2, 0, 1, 0, "R8 fetch mismatch");
    issue(3, 5, 9, 0, 1, 0, "R4 fetch match");
    issue(0, 5, 2, 0, 1, 1, "R13 strict load");
    issue(2, 5, 2, 0, 1, 1, "R13 strict store");
    issue(1, 5, 2, 0, 1, 1, "R6 strict cap load");
    issue(0, 5, 9, 0, 0, 0, "R9 perm fail");
    issue(7, 5, 0, 0, 1, 0, "R9 reserved op");
    issue(4, 5, 3, 7, 1, 0, "R10 versioned set");
    issue(5, 5, 0, 0, 1, 0, "R10 unchanged after refused set");
    issue(5, 5, 9, 0, 1, 0, "R11 versioned read");
    issue(4, 5, 0, 0, 1, 0, "R10 set to zero");
    issue(0, 5, 9, 0, 1, 0, "R4 versioned on zero granule");
    issue(0, 5, 0, 0, 1, 0, "R3 unversioned on zero granule");
    issue(4, 8, 0, 7, 1, 0, "R10 set 8");
    issue(0, 8, 7, 0, 1, 0, "R10 use right after set");
    idle();

    for (int n = 0; n < 400; n++) begin
      int op, cv;
      op = $urandom_range(0, 7);
      cv = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 3);
      issue(op, $urandom_range(0, 15), cv, $urandom_range(0, 3),
            $urandom_range(0, 9) != 0, $urandom_range(0, 3) == 0, "R4 R12 random");
    end
    idle();

    derive(0, 1, 5, 5, 1, 0, "R14 unversioned source");
    derive(0, 0, 3, 3, 0, 0, "R14 untagged source");
    derive(5, 1, 5, 5, 1, 0, "R14 equal versions");
    derive(5, 1, 6, 6, 0, 0, "R14 different versions");
    derive(5, 1, 0, 0, 0, 1, "R14 request zero");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule